// File: doc/BRIEF.md
# Sleep-Mode Clock Gating Controller

This block decides which clocks of a small processor keep ticking while it sits in a reduced-power idle state, and when it wakes. Every clock is modelled as a one-cycle enable strobe on a free-running sampling clock: the PLL output arrives as `pll_tick`, the reference oscillator as `ref_tick`. The block turns these into gated enables for the master clock, the CPU clock and each timer, and it holds the sleep flag that the idle request sets and a wake interrupt clears.

A control register image configures it. Two bits enable the reference oscillator (either one suffices). An idle-hold bit chooses between a light sleep, where the PLL master clock keeps running, and a deep sleep, where everything halts except timers fed from the reference oscillator. An arm bit chooses how interrupts wake the part. When clear, interrupts are sampled on master-clock edges. When set, they are caught by a set-only latch and passed through a synchronizer, so a wake works even with the master clock stopped.

Top module: `slp_clk_ctrl`

## Requirements
- R1: `ref_osc_en` equals control bit 8 OR control bit 9 at all times, and entering or leaving sleep never changes it.
- R2: `asleep` rises after the first clock edge at which `idle_req`, `pll_tick` and not `asleep` hold together. `idle_req` without `pll_tick` has no effect.
- R3: `cpu_en` is low whenever `asleep` is high, in both sleep depths. While awake, `cpu_en` equals `pll_tick`.
- R4: While asleep with the idle-hold bit (control bit 10) clear, `mc_en` equals `pll_tick` AND `ref_osc_en`. While awake, `mc_en` equals `pll_tick`.
- R5: While asleep with the idle-hold bit set, `mc_en` is low, and every timer sourced from the master clock gets no enable.
- R6: A timer whose `tmr_src` bit is 1 (reference source) gets `ref_tick` AND `ref_osc_en` at all times. A timer whose bit is 0 gets `mc_en`.
- R7: With the arm bit (control bit 11) clear, an interrupt high at a cycle where `mc_en` is high while asleep clears `asleep` after that edge.
- R8: With the arm bit clear and `mc_en` low while asleep, interrupts have no effect, and the block stays asleep.
- R9: With the arm bit set, an interrupt high for one cycle while asleep wakes the block even with `pll_tick` low. `asleep` falls SYNC_STAGES+1 edges after the capturing edge (3 with the default of 2).
- R10: Each of the seven `irq` lines can wake the block on its own. Bit 0 is timer 1, bit 1 is timer 2, bit 2 is port F, and bits 3 to 6 are port D lines 2 to 5.
- R11: `wake` is a single-cycle pulse, high exactly in the first cycle after `asleep` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | CTRL_W | Control register image |
| tmr_src | input | N_TMR | Per-timer source: 1 = reference oscillator, 0 = master clock |
| idle_req | input | 1 | Idle request from the CPU |
| pll_tick | input | 1 | PLL master-clock strobe |
| ref_tick | input | 1 | Reference-oscillator strobe |
| irq | input | N_IRQ | Wake-capable interrupt lines |
| mc_en | output | 1 | Gated master-clock enable |
| cpu_en | output | 1 | Gated CPU-clock enable |
| tmr_en | output | N_TMR | Gated timer-clock enables |
| ref_osc_en | output | 1 | Reference-oscillator enable |
| asleep | output | 1 | Sleep flag |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The bench builds the block with its defaults: two timers, seven interrupt lines and a two-stage synchronizer. That small size lets it sweep every value of the idle-hold bit, the arm bit, both timer-source bits and all four oscillator-enable bit patterns, and, for each of these, try every interrupt line as the wake source. A bench-side model predicts each enable, the sleep flag and the wake pulse cycle by cycle. This brings in reach the cases where the part must never wake (synchronous mode with the master clock stopped) and the exact synchronizer latency in the asynchronous mode.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef struct packed {
      logic ref_on;
      logic idle_hold;
      logic arm;
   } slp_cfg_t;
endpackage

// File: rtl/slp_clk_gate.sv
module slp_clk_gate #(
   parameter int N_TMR = 2
) (
   input  logic             asleep,
   input  slp_pkg::slp_cfg_t cfg,
   input  logic             pll_tick,
   input  logic             ref_tick,
   input  logic [N_TMR-1:0] tmr_src,
   output logic             mc_en,
   output logic             cpu_en,
   output logic [N_TMR-1:0] tmr_en
);
   logic ref_clk;

   always_comb begin
      if (!asleep)            mc_en = pll_tick;
      else if (cfg.idle_hold) mc_en = 1'b0;
      else                    mc_en = pll_tick & cfg.ref_on;
   end

   assign cpu_en  = pll_tick & ~asleep;
   assign ref_clk = ref_tick & cfg.ref_on;

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      assign tmr_en[t] = tmr_src[t] ? ref_clk : mc_en;
   end
endmodule

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
   parameter int N_IRQ       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             asleep,
   input  logic             arm,
   input  logic             mc_en,
   input  logic [N_IRQ-1:0] irq,
   output logic             wake_go
);
   logic             any_irq;
   logic             cap_latch;
   logic [SYNC_STAGES-1:0] sync_q;
   logic             sync_go;
   logic             async_go;

   assign any_irq  = |irq;
   assign sync_go  = asleep & ~arm & mc_en & any_irq;
   assign async_go = asleep & arm & sync_q[SYNC_STAGES-1];
   assign wake_go  = sync_go | async_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cap_latch <= 1'b0;
      else if (async_go)         cap_latch <= 1'b0;
      else if (asleep && arm && any_irq) cap_latch <= 1'b1;
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sync_q[s] <= 1'b0;
         else if (async_go) sync_q[s] <= 1'b0;
         else if (s == 0)   sync_q[s] <= cap_latch;
         else               sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end

   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_latch && asleep && !async_go) |=> cap_latch);
endmodule

// File: rtl/slp_sleep_fsm.sv
module slp_sleep_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req,
   input  logic pll_tick,
   input  logic wake_go,
   output logic asleep,
   output logic wake
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep <= 1'b0;
         wake   <= 1'b0;
      end else begin
         wake <= asleep & wake_go;
         if (asleep && wake_go)                  asleep <= 1'b0;
         else if (!asleep && pll_tick && idle_req) asleep <= 1'b1;
      end
   end
endmodule

// File: rtl/slp_clk_ctrl.sv
module slp_clk_ctrl #(
   parameter int CTRL_W      = 16,
   parameter int REF_BIT_A   = 8,
   parameter int REF_BIT_B   = 9,
   parameter int HOLD_BIT    = 10,
   parameter int ARM_BIT     = 11,
   parameter int N_TMR       = 2,
   parameter int N_IRQ       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [N_TMR-1:0]  tmr_src,
   input  logic              idle_req,
   input  logic              pll_tick,
   input  logic              ref_tick,
   input  logic [N_IRQ-1:0]  irq,
   output logic              mc_en,
   output logic              cpu_en,
   output logic [N_TMR-1:0]  tmr_en,
   output logic              ref_osc_en,
   output logic              asleep,
   output logic              wake
);
   localparam int MAX_BIT = CTRL_W - 1;

   if (REF_BIT_A > MAX_BIT || REF_BIT_B > MAX_BIT ||
       HOLD_BIT > MAX_BIT || ARM_BIT > MAX_BIT) begin : g_bad_bit
      $error("control bit position outside register image");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (N_TMR < 1 || N_IRQ < 1) begin : g_bad_cnt
      $error("timer and interrupt counts must be positive");
   end

   slp_pkg::slp_cfg_t cfg;
   logic wake_go;
   logic unused_ctrl;

   assign cfg.ref_on    = ctrl[REF_BIT_A] | ctrl[REF_BIT_B];
   assign cfg.idle_hold = ctrl[HOLD_BIT];
   assign cfg.arm       = ctrl[ARM_BIT];
   assign ref_osc_en    = cfg.ref_on;
   assign unused_ctrl   = ^ctrl;

   slp_sleep_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pll_tick(pll_tick),
      .wake_go(wake_go), .asleep(asleep), .wake(wake)
   );

   slp_wake_detect #(.N_IRQ(N_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk(clk), .rst_n(rst_n), .asleep(asleep), .arm(cfg.arm),
      .mc_en(mc_en), .irq(irq), .wake_go(wake_go)
   );

   slp_clk_gate #(.N_TMR(N_TMR)) u_gate (
      .asleep(asleep), .cfg(cfg), .pll_tick(pll_tick), .ref_tick(ref_tick),
      .tmr_src(tmr_src), .mc_en(mc_en), .cpu_en(cpu_en), .tmr_en(tmr_en)
   );

   // R3
   cpu_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !cpu_en);
   // R5
   mc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && cfg.idle_hold) |-> !mc_en);
   // R2
   enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && pll_tick && idle_req) |=> asleep);
   // R8
   sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !cfg.arm && !mc_en && $stable(ctrl)) |=> asleep);
   // R11
   wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (!asleep && $past(asleep)));
endmodule

// File: tb/sim_slp_clk_ctrl.sv
module sim_slp_clk_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctrl = 16'h0;
   logic [1:0]  tmr_src = 2'b0;
   logic        idle_req = 1'b0, pll_tick = 1'b0, ref_tick = 1'b0;
   logic [6:0]  irq = 7'h0;
   logic        mc_en, cpu_en, ref_osc_en, asleep, wake;
   logic [1:0]  tmr_en;

   int n_chk = 0, n_fail = 0;
   logic m_asleep = 1'b0, m_wake = 1'b0, m_pend = 1'b0;
   int   m_cd = 0;
   logic c_ref, c_hold, c_arm;

   always #5 clk = ~clk;

   slp_clk_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tmr_src(tmr_src),
      .idle_req(idle_req), .pll_tick(pll_tick), .ref_tick(ref_tick), .irq(irq),
      .mc_en(mc_en), .cpu_en(cpu_en), .tmr_en(tmr_en), .ref_osc_en(ref_osc_en),
      .asleep(asleep), .wake(wake)
   );

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b (hold=%b arm=%b ref=%b src=%b)",
                  tag, act, exp, c_hold, c_arm, c_ref, tmr_src);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; idle_req = 1'b0; pll_tick = 1'b0; ref_tick = 1'b0; irq = '0;
      @(negedge clk);
      rst_n = 1'b1;
      m_asleep = 1'b0; m_wake = 1'b0; m_pend = 1'b0; m_cd = 0;
   endtask

   task automatic step(input logic p, input logic r, input logic [6:0] iq, input logic idl);
      logic e_mc, e_ref;
      @(negedge clk);
      pll_tick = p; ref_tick = r; irq = iq; idle_req = idl;
      #1;
      e_mc  = !m_asleep ? p : (c_hold ? 1'b0 : (p & c_ref));
      e_ref = r & c_ref;
      chk("R1 ref_osc_en", {1'b0, ref_osc_en}, {1'b0, c_ref});
      chk("R4 R5 mc_en", {1'b0, mc_en}, {1'b0, e_mc});
      chk("R3 cpu_en", {1'b0, cpu_en}, {1'b0, p & !m_asleep});
      // R6 per-timer source selection
      chk("R6 tmr_en", tmr_en, {tmr_src[1] ? e_ref : e_mc, tmr_src[0] ? e_ref : e_mc});
      chk("R2 R7 R8 R9 asleep", {1'b0, asleep}, {1'b0, m_asleep});
      chk("R11 wake", {1'b0, wake}, {1'b0, m_wake});
      // model of the next clock edge
      m_wake = 1'b0;
      if (!m_asleep) begin
         if (p && idl) m_asleep = 1'b1;
      end else if (!c_arm) begin
         if (e_mc && (iq != 0)) begin m_asleep = 1'b0; m_wake = 1'b1; end
      end else if (m_pend) begin
         if (m_cd == 2) begin
            m_asleep = 1'b0; m_wake = 1'b1; m_pend = 1'b0; m_cd = 0;
         end else m_cd++;
      end else if (iq != 0) begin
         m_pend = 1'b1; m_cd = 0;
      end
   endtask

   initial begin
      c_ref = 1'b0; c_hold = 1'b0; c_arm = 1'b0;
      do_reset();
      #1;
      chk("R2 reset asleep", {1'b0, asleep}, 2'b00);
      chk("R11 reset wake", {1'b0, wake}, 2'b00);
      for (int h = 0; h < 2; h++)
         for (int a = 0; a < 2; a++)
            for (int s = 0; s < 4; s++)
               for (int rb = 0; rb < 4; rb++)
                  for (int j = 0; j < 7; j++) begin
                     do_reset();
                     c_hold = h[0]; c_arm = a[0]; c_ref = rb[0] | rb[1];
                     ctrl = {4'h0, a[0], h[0], rb[1], rb[0], 8'h5A};
                     tmr_src = s[1:0];
                     step(0, 0, 0, 0);
                     step(1, 1, 0, 0);
                     step(0, 1, 0, 1);     // R2 no entry without pll_tick
                     step(1, 0, 0, 1);     // R2 entry
                     step(1, 1, 0, 0);
                     step(0, 1, 0, 0);
                     step(1, 0, 0, 0);
                     step(0, 0, 0, 0);
                     // R10 line j alone; R9 async with pll low, R7/R8 sync
                     if (c_arm) step(0, 0, 7'(1 << j), 0);
                     else       step(1, 0, 7'(1 << j), 0);
                     for (int k = 0; k < 6; k++) step(k[0], 1, 0, 0);
                  end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1500000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule